// File: doc/BRIEF.md
# Receive DPLL Lane Override Sequencer

This block drives a PHY register access engine to force the receive DPLL mode of one SerDes lane. An override command starts a bounded poll of the lane's status register, which ends when the half-rate flag clears or the poll budget runs out. The block then reads a fresh status word as its working copy. Five writes to the lane's override register follow, always in this order: override enable off, enable on, mode field replaced, DPLL reset raised, DPLL reset lowered. A settle interval follows before the block reports completion.

A second command, disable, performs one status read and one write to the override register with the enable bit cleared. It has no poll and no settle interval. The lane number and mode value are captured when a command is accepted. No further command is taken until the running one finishes. After a link reset, the mode value normally supplied is 3.

Top module: `dpll_ovr_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `req_valid`, `busy` and `done` are low.
- R2: An override begins with reads of the status register at 0x2002 + lane*0x100. Another read follows only while bit 0 (half-rate) of the returned data is 1. No more than POLL_MAX such reads are issued; after that the sequence continues regardless.
- R3: After the poll, the block issues one more status read and keeps its data as the base word.
- R4: Five writes then go to the override register at 0x2005 + lane*0x100, in this order and with this data: base with bit 14 cleared; base with bit 14 set; the previous word with bits 10:8 replaced by the mode value; that word with bit 11 set; that word with bit 11 cleared.
- R5: A request keeps its valid, direction, address and data unchanged until the cycle in which `req_ack` is high.
- R6: After the last override write is acknowledged, the block waits exactly SETTLE_CYC cycles. `done` is then high for exactly one cycle.
- R7: A disable issues one status read and then one write of that data, with bit 14 cleared, to the override register. `done` is high in the cycle after that write is acknowledged.
- R8: Commands that arrive while `busy` is high, including in the cycle `done` is high, are ignored. Lane and mode are taken from the inputs in the cycle the command is accepted.
- R9: When override and disable are requested in the same cycle, only the override runs.
- R10: `busy` is high from the cycle after a command is accepted through the cycle in which `done` is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_ovr | input | 1 | Start the override sequence |
| go_dis | input | 1 | Start the disable sequence |
| lane_sel | input | 2 | Lane within the PHY |
| mode_val | input | 3 | DPLL mode value to insert |
| req_valid | output | 1 | Register request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 16 | PHY register address |
| req_wdata | output | 16 | Write data |
| req_ack | input | 1 | Access engine completes the pending request |
| rsp_rdata | input | 16 | Read data, valid with `req_ack` on reads |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with POLL_MAX = 6 and SETTLE_CYC = 20. With a poll budget of six, a status model that reports half-rate for ten reads exhausts the budget, so the base read returns with bit 0 still set. A short run of half-rate reads ends the poll early instead. With a 20-cycle settle, the exact cycle of `done` can be checked, and commands injected during a run or in the done cycle land while the block is busy.

// File: rtl/dpll_ovr_pkg.sv
package dpll_ovr_pkg;

    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 16;
    localparam int LANE_W     = 2;
    localparam int MODE_W     = 3;
    localparam int LANE_SHIFT = 8;

    localparam int HALF_BIT   = 0;
    localparam int MODE_LSB   = 8;
    localparam int RST_BIT    = 11;
    localparam int EN_BIT     = 14;

    localparam logic [ADDR_W-1:0] STAT_OFS = 16'h2002;
    localparam logic [ADDR_W-1:0] OVR_OFS  = 16'h2005;
    localparam logic [ADDR_W-1:0] LANE_FLD =
        ADDR_W'(((1 << LANE_W) - 1) << LANE_SHIFT);

    localparam logic [DATA_W-1:0] EN_MASK   = DATA_W'(1) << EN_BIT;
    localparam logic [DATA_W-1:0] RST_MASK  = DATA_W'(1) << RST_BIT;
    localparam logic [DATA_W-1:0] MODE_MASK =
        DATA_W'(((1 << MODE_W) - 1) << MODE_LSB);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POLL,
        ST_BASE,
        ST_WR_CLR,
        ST_WR_SET,
        ST_WR_MODE,
        ST_WR_RST_HI,
        ST_WR_RST_LO,
        ST_SETTLE,
        ST_FIN
    } step_e;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_req_t;

    function automatic logic [ADDR_W-1:0] lane_addr(
        input logic [ADDR_W-1:0] ofs, input logic [LANE_W-1:0] lane);
        return ofs + (ADDR_W'(lane) << LANE_SHIFT);
    endfunction

    function automatic logic [DATA_W-1:0] put_mode(
        input logic [DATA_W-1:0] word, input logic [MODE_W-1:0] mode);
        return (word & ~MODE_MASK) | (DATA_W'(mode) << MODE_LSB);
    endfunction

endpackage

// File: rtl/dpll_ovr_counter.sv
module dpll_ovr_counter #(
    parameter int MAX = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int W = (MAX > 1) ? $clog2(MAX) : 1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign last = (cnt_q == W'(MAX - 1));
endmodule

// File: rtl/dpll_ovr_fsm.sv
module dpll_ovr_fsm
    import dpll_ovr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go_ovr,
    input  logic              go_dis,
    input  logic [LANE_W-1:0] lane_in,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              ack,
    input  logic [DATA_W-1:0] rdata,
    input  logic              poll_last,
    input  logic              settle_last,
    output step_e             step,
    output logic [LANE_W-1:0] lane_q,
    output logic [MODE_W-1:0] mode_q,
    output logic [DATA_W-1:0] base_q,
    output logic              poll_clr,
    output logic              poll_inc,
    output logic              settle_clr,
    output logic              settle_inc,
    output logic              busy,
    output logic              done
);
    step_e st_q, st_d;
    logic  dis_q;
    logic  accept;

    assign accept = (st_q == ST_IDLE) && (go_ovr || go_dis);

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: begin
                if (go_ovr)      st_d = ST_POLL;
                else if (go_dis) st_d = ST_BASE;
            end
            ST_POLL: begin
                if (ack && !(rdata[HALF_BIT] && !poll_last)) st_d = ST_BASE;
            end
            ST_BASE:      if (ack) st_d = ST_WR_CLR;
            ST_WR_CLR:    if (ack) st_d = dis_q ? ST_FIN : ST_WR_SET;
            ST_WR_SET:    if (ack) st_d = ST_WR_MODE;
            ST_WR_MODE:   if (ack) st_d = ST_WR_RST_HI;
            ST_WR_RST_HI: if (ack) st_d = ST_WR_RST_LO;
            ST_WR_RST_LO: if (ack) st_d = ST_SETTLE;
            ST_SETTLE:    if (settle_last) st_d = ST_FIN;
            ST_FIN:       st_d = ST_IDLE;
            default:      st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            dis_q  <= 1'b0;
            lane_q <= '0;
            mode_q <= '0;
            base_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                lane_q <= lane_in;
                mode_q <= mode_in;
                dis_q  <= !go_ovr;
            end
            if (st_q == ST_BASE && ack) begin
                base_q <= rdata;
            end
        end
    end

    assign step       = st_q;
    assign poll_clr   = (st_q == ST_IDLE);
    assign poll_inc   = (st_q == ST_POLL) && ack && rdata[HALF_BIT] && !poll_last;
    assign settle_clr = (st_q != ST_SETTLE);
    assign settle_inc = (st_q == ST_SETTLE);
    assign busy       = (st_q != ST_IDLE);
    assign done       = (st_q == ST_FIN);
endmodule

// File: rtl/dpll_ovr_reqgen.sv
module dpll_ovr_reqgen
    import dpll_ovr_pkg::*;
(
    input  step_e             step,
    input  logic [LANE_W-1:0] lane,
    input  logic [MODE_W-1:0] mode,
    input  logic [DATA_W-1:0] base,
    output logic              valid,
    output reg_req_t          req
);
    logic [DATA_W-1:0] w_set, w_mode;

    assign w_set  = base | EN_MASK;
    assign w_mode = put_mode(w_set, mode);

    always_comb begin
        valid      = 1'b1;
        req.write  = 1'b1;
        req.addr   = lane_addr(OVR_OFS, lane);
        req.data   = '0;
        case (step)
            ST_POLL, ST_BASE: begin
                req.write = 1'b0;
                req.addr  = lane_addr(STAT_OFS, lane);
            end
            ST_WR_CLR:    req.data = base & ~EN_MASK;
            ST_WR_SET:    req.data = w_set;
            ST_WR_MODE:   req.data = w_mode;
            ST_WR_RST_HI: req.data = w_mode | RST_MASK;
            ST_WR_RST_LO: req.data = w_mode & ~RST_MASK;
            default: begin
                valid     = 1'b0;
                req.write = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/dpll_ovr_seq.sv
module dpll_ovr_seq
    import dpll_ovr_pkg::*;
#(
    parameter int POLL_MAX   = 1000,
    parameter int SETTLE_CYC = 1500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_ovr,
    input  logic              go_dis,
    input  logic [LANE_W-1:0] lane_sel,
    input  logic [MODE_W-1:0] mode_val,
    output logic              req_valid,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              req_ack,
    input  logic [DATA_W-1:0] rsp_rdata,
    output logic              busy,
    output logic              done
);
    step_e             step;
    logic [LANE_W-1:0] lane_q;
    logic [MODE_W-1:0] mode_q;
    logic [DATA_W-1:0] base_q;
    logic              poll_clr, poll_inc, poll_last;
    logic              settle_clr, settle_inc, settle_last;
    reg_req_t          req;

    dpll_ovr_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .go_ovr      (go_ovr),
        .go_dis      (go_dis),
        .lane_in     (lane_sel),
        .mode_in     (mode_val),
        .ack         (req_ack),
        .rdata       (rsp_rdata),
        .poll_last   (poll_last),
        .settle_last (settle_last),
        .step        (step),
        .lane_q      (lane_q),
        .mode_q      (mode_q),
        .base_q      (base_q),
        .poll_clr    (poll_clr),
        .poll_inc    (poll_inc),
        .settle_clr  (settle_clr),
        .settle_inc  (settle_inc),
        .busy        (busy),
        .done        (done)
    );

    dpll_ovr_counter #(.MAX(POLL_MAX)) u_poll_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (poll_clr),
        .inc  (poll_inc),
        .last (poll_last)
    );

    dpll_ovr_counter #(.MAX(SETTLE_CYC)) u_settle_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (settle_clr),
        .inc  (settle_inc),
        .last (settle_last)
    );

    dpll_ovr_reqgen u_reqgen (
        .step  (step),
        .lane  (lane_q),
        .mode  (mode_q),
        .base  (base_q),
        .valid (req_valid),
        .req   (req)
    );

    assign req_write = req.write;
    assign req_addr  = req.addr;
    assign req_wdata = req.data;
endmodule

// File: rtl/dpll_ovr_seq_chk.sv
module dpll_ovr_seq_chk
    import dpll_ovr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              req_ack,
    input logic              busy,
    input logic              done
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!req_valid && !busy && !done));

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_write) &&
                                     $stable(req_addr) && $stable(req_wdata)));

    // R2
    read_target_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |-> ((req_addr & ~LANE_FLD) == STAT_OFS));

    // R4
    write_target_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |-> ((req_addr & ~LANE_FLD) == OVR_OFS));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (done || req_valid) |-> busy);

    // R8
    lane_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && $past(req_valid)) |->
            ((req_addr & LANE_FLD) == ($past(req_addr) & LANE_FLD)));
endmodule

bind dpll_ovr_seq dpll_ovr_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ack   (req_ack),
    .busy      (busy),
    .done      (done)
);

// File: tb/dpll_ovr_seq_tb.sv
module dpll_ovr_seq_tb;
    localparam int P = 6;
    localparam int S = 20;
    localparam logic [15:0] STAT_BASE = 16'hCDAE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go_ovr = 1'b0, go_dis = 1'b0;
    logic [1:0]  lane_sel = 2'd0;
    logic [2:0]  mode_val = 3'd0;
    logic        req_valid, req_write, busy, done;
    logic [15:0] req_addr, req_wdata;
    logic        req_ack = 1'b0;
    logic [15:0] rsp_rdata = 16'h0;

    always #5 clk = ~clk;

    dpll_ovr_seq #(.POLL_MAX(P), .SETTLE_CYC(S)) u_dut (
        .clk(clk), .rst(rst), .go_ovr(go_ovr), .go_dis(go_dis),
        .lane_sel(lane_sel), .mode_val(mode_val),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ack(req_ack), .rsp_rdata(rsp_rdata),
        .busy(busy), .done(done)
    );

    int n_chk = 0, n_bad = 0;
    int hr_left = 0, wcnt = 0, ack_total = 0;
    logic [32:0] q_req[$];
    string       q_tag[$];
    bit          m_busy = 0, m_fin = 0, m_ovr = 0;
    int          m_cnt = 0;
    bit          hold_prev = 0;
    logic [32:0] held;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic build(input bit ovr, input logic [1:0] ln,
                         input logic [2:0] md, input int h);
        logic [15:0] sa, oa, base, w2, w3;
        int n;
        sa = 16'h2002 + {6'd0, ln, 8'd0};
        oa = 16'h2005 + {6'd0, ln, 8'd0};
        n = 0;
        if (ovr) begin
            n = (h + 1 < P) ? h + 1 : P;
            for (int i = 0; i < n; i++) begin
                q_req.push_back({1'b0, sa, 16'h0}); q_tag.push_back("R2");
            end
        end
        base = STAT_BASE | ((h > n) ? 16'h1 : 16'h0);
        q_req.push_back({1'b0, sa, 16'h0});
        q_tag.push_back(ovr ? "R3" : "R7");
        q_req.push_back({1'b1, oa, base & ~16'h4000});
        q_tag.push_back(ovr ? "R4" : "R7");
        if (ovr) begin
            w2 = base | 16'h4000;
            w3 = (w2 & ~16'h0700) | ({13'd0, md} << 8);
            q_req.push_back({1'b1, oa, w2});             q_tag.push_back("R4");
            q_req.push_back({1'b1, oa, w3});             q_tag.push_back("R4");
            q_req.push_back({1'b1, oa, w3 | 16'h0800});  q_tag.push_back("R4");
            q_req.push_back({1'b1, oa, w3 & ~16'h0800}); q_tag.push_back("R4");
        end
        m_ovr  = ovr;
        m_busy = 1;
        m_fin  = 0;
    endtask

    // reference model and access-engine state, advanced at each rising edge
    always @(posedge clk) begin
        if (rst) begin
            q_req.delete(); q_tag.delete();
            m_busy = 0; m_fin = 0; m_cnt = 0; wcnt = 0;
        end else begin
            if (req_ack) begin
                wcnt = 0; ack_total++;
                if (!req_write && hr_left > 0) hr_left--;
            end else if (req_valid) begin
                wcnt++;
            end
            if (m_busy) begin
                if (m_fin) begin
                    if (m_cnt == 0) begin m_busy = 0; m_fin = 0; end
                    else m_cnt--;
                end else if (req_ack && q_req.size() > 0) begin
                    void'(q_req.pop_front()); void'(q_tag.pop_front());
                    if (q_req.size() == 0) begin
                        m_fin = 1; m_cnt = m_ovr ? S : 0;
                    end
                end
            end else if (go_ovr) begin
                build(1'b1, lane_sel, mode_val, hr_left);
            end else if (go_dis) begin
                build(1'b0, lane_sel, mode_val, hr_left);
            end
        end
    end

    // engine response and comparison, away from the active edge
    always @(negedge clk) begin
        bit exp_v, exp_d;
        string t;
        req_ack   = req_valid && (wcnt >= (ack_total % 3));
        rsp_rdata = STAT_BASE | ((hr_left > 0) ? 16'h1 : 16'h0);
        exp_v = m_busy && !m_fin && q_req.size() > 0;
        exp_d = m_busy && m_fin && m_cnt == 0;
        chk(busy == m_busy, rst ? "R1" : "R10", 32'(busy), 32'(m_busy));
        chk(done == exp_d, rst ? "R1" : (m_ovr ? "R6" : "R7"),
            32'(done), 32'(exp_d));
        t = (q_tag.size() > 0) ? q_tag[0] : "R1";
        chk(req_valid == exp_v, t, 32'(req_valid), 32'(exp_v));
        if (req_valid && exp_v) begin
            chk({req_write, req_addr} == q_req[0][32:16], t,
                32'({req_write, req_addr}), 32'(q_req[0][32:16]));
            if (req_write)
                chk(req_wdata == q_req[0][15:0], t,
                    32'(req_wdata), 32'(q_req[0][15:0]));
        end
        if (hold_prev && !rst)
            chk(req_valid && {req_write, req_addr, req_wdata} == held, "R5",
                32'({req_write, req_addr}), 32'(held[32:16]));
        hold_prev = req_valid && !req_ack && !rst;
        held = {req_write, req_addr, req_wdata};
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        finish_run();
    end

    task automatic wait_idle();
        @(negedge clk);
        while (m_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic run(input bit ovr, input bit dis, input logic [1:0] ln,
                       input logic [2:0] md, input int h);
        @(negedge clk);
        lane_sel = ln; mode_val = md; hr_left = h;
        go_ovr = ovr; go_dis = dis;
        @(negedge clk);
        go_ovr = 0; go_dis = 0;
    endtask

    initial begin
        int a0;
        repeat (3) @(negedge clk);
        // R1: quiet during reset
        chk(!req_valid && !busy && !done, "R1", 32'({req_valid, busy, done}), 32'd0);
        rst = 0;
        repeat (3) @(negedge clk);

        // R2 R3 R4 R6: no half-rate, post-reset mode 3
        run(1, 0, 2'd0, 3'd3, 0); wait_idle();
        // R2: poll ends early after two half-rate reads
        run(1, 0, 2'd3, 3'd5, 2); wait_idle();
        // R2: poll budget exhausted, base keeps bit 0
        run(1, 0, 2'd1, 3'd7, 10); wait_idle();
        // R7: disable only
        run(0, 1, 2'd2, 3'd0, 1); wait_idle();

        // R8: commands and new lane/mode during a run are ignored
        a0 = ack_total;
        run(1, 0, 2'd2, 3'd0, 1);
        repeat (3) @(negedge clk);
        go_dis = 1; lane_sel = 2'd0; mode_val = 3'd7;
        @(negedge clk);
        go_dis = 0;
        wait_idle();
        chk(ack_total - a0 == 8, "R8", 32'(ack_total - a0), 32'd8);

        // R9: both commands together run the override only
        a0 = ack_total;
        run(1, 1, 2'd1, 3'd3, 0); wait_idle();
        chk(ack_total - a0 == 7, "R9", 32'(ack_total - a0), 32'd7);

        // R8: command in the done cycle is ignored
        a0 = ack_total;
        run(0, 1, 2'd3, 3'd2, 0);
        while (!done) @(negedge clk);
        go_ovr = 1;
        @(negedge clk);
        go_ovr = 0;
        repeat (4) @(negedge clk);
        chk(!busy && ack_total - a0 == 2, "R8", 32'(ack_total - a0), 32'd2);

        finish_run();
    end
endmodule